// File: doc/BRIEF.md
# Companion GPIO and Control Register Block

This block is a small memory-mapped register file for a companion device. A host writes 16-bit control words into a set of storage registers (mode, card detect, card control, interrupt raw, interrupt mask, interrupt status and a pin-read register). The block also holds a read-only status word, a power register with a forced-bit rule, and a 16-pin general-purpose output port.

The output port is controlled by a direction register and a level register. The level actually driven on a pin is the level bit ANDed with the direction bit. After any write to either register, a two-state reporting machine compares the newly driven pattern with the last one it reported. For one cycle it pulses a change strobe on every pin that moved, and it then records the new pattern as reported. The machine has two states. In ST_IDLE it is waiting. In ST_REPORT the strobes are valid. A direction or level write takes ST_IDLE to ST_REPORT and keeps the machine in ST_REPORT. Any other cycle takes ST_REPORT back to ST_IDLE. Neighbouring logic consumes the strobes, the reported levels and the live levels.

Top module: `cmp_companion`

## Requirements
- R1: After reset, every register reads 0x0000 except the status register at offset 0x08, which reads 0x0002 (ready). `pin_out` is 0 and `pin_chg` is 0.
- R2: A write to a storage register stores the 16-bit data word, and a later read returns it. The storage registers are at offsets 0x00 (mode), 0x04 (card detect), 0x10 (card control), 0x14 (interrupt raw), 0x18 (interrupt mask), 0x1C (interrupt status) and 0x28 (pin read).
- R3: The status register at 0x08 ignores writes and always reads 0x0002.
- R4: A write to the power register at 0x0C stores the data. If data bit 7 is 1, bits 15 and 6 are also set (data OR 0x8040).
- R5: A write to the level register at 0x24 stores the data ANDed with the current direction register at 0x20.
- R6: A direction write changes only the direction register and leaves the stored level unchanged. `pin_val` always equals level AND direction.
- R7: In the cycle after a direction or level write edge, `pin_chg` equals the last reported pattern XOR the new `pin_val`, for exactly one cycle. `pin_out` takes the new pattern at the next edge.
- R8: A write to any register other than direction or level produces no strobe and leaves `pin_out` unchanged.
- R9: A read of an unmapped offset returns 0, and a write to an unmapped offset changes no register and produces no strobe.
- R10: On back-to-back direction and level writes, each strobe is computed against the pattern that the previous write produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pin_out | output | 16 | Last reported driven pin pattern |
| pin_chg | output | 16 | One-cycle change strobe, one bit per pin |
| pin_val | output | 16 | Live driven pattern (level AND direction) |

## Verification
The hardest situation to reach is back-to-back writes to the direction and level registers. Here the machine stays in ST_REPORT while the reference pattern moves underneath it. A loose single-write bench never reaches this case. The bench issues a direction write and a level write on adjacent edges and checks both strobes against a reference model. It also runs a case where a direction shrink followed by a direction expand brings back previously hidden level bits. A long alternating sweep of computed direction and level patterns keeps the model's reported pattern in step with the port.

// File: rtl/cmp_regs_pkg.sv
package cmp_regs_pkg;

    localparam logic [7:0] OFF_MODE     = 8'h00;
    localparam logic [7:0] OFF_CARD_DET = 8'h04;
    localparam logic [7:0] OFF_STATUS   = 8'h08;
    localparam logic [7:0] OFF_POWER    = 8'h0C;
    localparam logic [7:0] OFF_CARD_CTL = 8'h10;
    localparam logic [7:0] OFF_IRQ_RAW  = 8'h14;
    localparam logic [7:0] OFF_IRQ_MASK = 8'h18;
    localparam logic [7:0] OFF_IRQ_STAT = 8'h1C;
    localparam logic [7:0] OFF_PIN_DIR  = 8'h20;
    localparam logic [7:0] OFF_PIN_LVL  = 8'h24;
    localparam logic [7:0] OFF_PIN_RD   = 8'h28;

    localparam int N_PLAIN = 7;
    localparam int PWR_TRIG_BIT = 7;
    localparam int PWR_LOW_FORCE_BIT = 6;
    localparam logic [15:0] STATUS_READY = 16'h0002;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } rpt_state_e;

    function automatic logic [7:0] plain_offset(input int idx);
        case (idx)
            0: plain_offset = OFF_MODE;
            1: plain_offset = OFF_CARD_DET;
            2: plain_offset = OFF_CARD_CTL;
            3: plain_offset = OFF_IRQ_RAW;
            4: plain_offset = OFF_IRQ_MASK;
            5: plain_offset = OFF_IRQ_STAT;
            default: plain_offset = OFF_PIN_RD;
        endcase
    endfunction

endpackage

// File: rtl/cmp_ctl_regs.sv
module cmp_ctl_regs
    import cmp_regs_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    output logic [N_PLAIN-1:0][DW-1:0] plain_q,
    output logic [DW-1:0]             power_q
);

    localparam logic [DW-1:0] PWR_FORCE =
        (DW'(1) << (DW - 1)) | (DW'(1) << PWR_LOW_FORCE_BIT);

    generate
        for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
            localparam logic [AW-1:0] OFF = AW'(plain_offset(g));
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && addr == OFF) begin
                    q <= wdata;
                end
            end
            assign plain_q[g] = q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            power_q <= '0;
        end else if (wr_en && addr == AW'(OFF_POWER)) begin
            power_q <= wdata | (wdata[PWR_TRIG_BIT] ? PWR_FORCE : '0);
        end
    end

endmodule

// File: rtl/cmp_gpio_regs.sv
module cmp_gpio_regs
    import cmp_regs_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] lvl_q,
    output logic [DW-1:0] eff,
    output logic          gpio_wr
);

    logic dir_hit;
    logic lvl_hit;

    assign dir_hit = wr_en && addr == AW'(OFF_PIN_DIR);
    assign lvl_hit = wr_en && addr == AW'(OFF_PIN_LVL);
    assign gpio_wr = dir_hit || lvl_hit;
    assign eff     = lvl_q & dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (dir_hit) begin
            dir_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (lvl_hit) begin
            lvl_q <= wdata & dir_q;
        end
    end

endmodule

// File: rtl/cmp_chg_fsm.sv
module cmp_chg_fsm
    import cmp_regs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gpio_wr,
    input  logic [DW-1:0] eff,
    output logic [DW-1:0] reported,
    output logic [DW-1:0] chg
);

    rpt_state_e state_q;
    rpt_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = gpio_wr ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = gpio_wr ? ST_REPORT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reported <= '0;
        end else if (state_q == ST_REPORT) begin
            reported <= eff;
        end
    end

    always_comb begin
        chg = '0;
        unique case (state_q)
            ST_IDLE:   chg = '0;
            ST_REPORT: chg = reported ^ eff;
        endcase
    end

endmodule

// File: rtl/cmp_read_mux.sv
module cmp_read_mux
    import cmp_regs_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic [AW-1:0]              addr,
    input  logic [N_PLAIN-1:0][DW-1:0] plain_q,
    input  logic [DW-1:0]              power_q,
    input  logic [DW-1:0]              dir_q,
    input  logic [DW-1:0]              lvl_q,
    output logic [DW-1:0]              rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_PLAIN; i++) begin
            if (addr == AW'(plain_offset(i))) begin
                rdata = plain_q[i];
            end
        end
        if (addr == AW'(OFF_STATUS))  rdata = DW'(STATUS_READY);
        if (addr == AW'(OFF_POWER))   rdata = power_q;
        if (addr == AW'(OFF_PIN_DIR)) rdata = dir_q;
        if (addr == AW'(OFF_PIN_LVL)) rdata = lvl_q;
    end

endmodule

// File: rtl/cmp_companion.sv
module cmp_companion
    import cmp_regs_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_chg,
    output logic [DW-1:0] pin_val
);

    logic [N_PLAIN-1:0][DW-1:0] plain_q;
    logic [DW-1:0] power_q;
    logic [DW-1:0] dir_q;
    logic [DW-1:0] lvl_q;
    logic          gpio_wr;

    cmp_ctl_regs #(.DW(DW), .AW(AW)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .plain_q (plain_q),
        .power_q (power_q)
    );

    cmp_gpio_regs #(.DW(DW), .AW(AW)) u_gpio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .eff     (pin_val),
        .gpio_wr (gpio_wr)
    );

    cmp_chg_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpio_wr  (gpio_wr),
        .eff      (pin_val),
        .reported (pin_out),
        .chg      (pin_chg)
    );

    cmp_read_mux #(.DW(DW), .AW(AW)) u_rd (
        .addr    (bus_addr),
        .plain_q (plain_q),
        .power_q (power_q),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/cmp_companion_chk.sv
module cmp_companion_chk
    import cmp_regs_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] pin_out,
    input logic [DW-1:0] pin_chg,
    input logic [DW-1:0] pin_val
);

    logic gpio_write;
    assign gpio_write = bus_wr &&
        (bus_addr == AW'(OFF_PIN_DIR) || bus_addr == AW'(OFF_PIN_LVL));

    // R2
    assert_mode_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFF_MODE)) ##1 (bus_addr == AW'(OFF_MODE))
        |-> bus_rdata == $past(bus_wdata));

    // R3
    assert_status_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(OFF_STATUS)) |-> bus_rdata == DW'(STATUS_READY));

    // R4
    assert_power_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFF_POWER) && bus_wdata[PWR_TRIG_BIT])
        ##1 (bus_addr == AW'(OFF_POWER))
        |-> (bus_rdata[DW-1] && bus_rdata[PWR_LOW_FORCE_BIT]));

    // R5
    assert_level_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFF_PIN_LVL)) ##1 (bus_addr == AW'(OFF_PIN_LVL))
        |-> bus_rdata == pin_val);

    // R7
    assert_out_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pin_out == $past(pin_val));

    // R7
    assert_quiet_means_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_chg == '0) |-> pin_out == pin_val);

    // R8
    assert_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_write |=> pin_chg == '0);

    // R9
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(8'h2C)) |-> bus_rdata == '0);

endmodule

bind cmp_companion cmp_companion_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_chg   (pin_chg),
    .pin_val   (pin_val)
);

// File: tb/cmp_companion_bench.sv
`timescale 1ns/1ps
module cmp_companion_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [15:0] pin_out;
    logic [15:0] pin_chg;
    logic [15:0] pin_val;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    cmp_companion u_cmp_companion (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .pin_chg   (pin_chg),
        .pin_val   (pin_val)
    );

    logic [15:0] m_dir = 16'h0, m_lvl = 16'h0, m_prev = 16'h0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [15:0] d, output logic [15:0] seen);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        seen = pin_chg;
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [15:0] model_gpio(input logic is_dir, input logic [15:0] d);
        logic [15:0] e;
        if (is_dir) m_dir = d; else m_lvl = d & m_dir;
        e = m_lvl & m_dir;
        model_gpio = m_prev ^ e;
        m_prev = e;
    endfunction

    localparam logic [7:0] PLAIN_OFFS [7] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h28};

    initial begin
        logic [15:0] v, s, e;
        logic [15:0] store [7];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values over the whole mapped space
        for (int a = 0; a < 12; a++) begin
            do_rd(8'(a * 4), v);
            chk(a == 2 ? "R1 status reset" : "R1 reg reset", v, a == 2 ? 16'h0002 : 16'h0000);
        end
        chk("R1 pin_out reset", pin_out, 16'h0);
        chk("R1 pin_chg reset", pin_chg, 16'h0);

        // R2 storage sweep, R8 no strobe on storage writes
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 7; r++) begin
                store[r] = 16'((r + 1) * 16'h1357 ^ (p * 16'h9A3C));
                do_wr(PLAIN_OFFS[r], store[r], s);
                chk("R8 no strobe on storage write", s, 16'h0);
            end
            for (int r = 0; r < 7; r++) begin
                do_rd(PLAIN_OFFS[r], v);
                chk("R2 storage readback", v, store[r]);
            end
        end

        // R3 status ignores writes
        do_wr(8'h08, 16'hFFFF, s);
        do_rd(8'h08, v);
        chk("R3 status after write", v, 16'h0002);

        // R4 power sweep
        for (int k = 0; k < 16; k++) begin
            v = 16'(k * 16'h1111) ^ (k[0] ? 16'h0080 : 16'h0000);
            e = v | (v[7] ? 16'h8040 : 16'h0000);
            do_wr(8'h0C, v, s);
            do_rd(8'h0C, v);
            chk("R4 power write rule", v, e);
        end

        // R9 unmapped offsets
        for (int u = 0; u < 4; u++) begin
            logic [7:0] ua;
            ua = (u == 0) ? 8'h01 : (u == 1) ? 8'h2C : (u == 2) ? 8'h30 : 8'hFC;
            do_wr(ua, 16'hFFFF, s);
            chk("R9 unmapped write no strobe", s, 16'h0);
            do_rd(ua, v);
            chk("R9 unmapped read zero", v, 16'h0);
        end
        do_rd(8'h00, v);
        chk("R9 mode untouched by unmapped write", v, store[0]);
        do_rd(8'h20, v);
        chk("R9 direction untouched by unmapped write", v, 16'h0);

        // R5 R6 R7 alternating direction and level sweep
        for (int i = 0; i < 48; i++) begin
            logic is_dir;
            logic [15:0] d;
            is_dir = (i % 2 == 0);
            d = 16'((i * 40503 + 4660) ^ (i << 9));
            e = model_gpio(is_dir, d);
            do_wr(is_dir ? 8'h20 : 8'h24, d, s);
            chk("R7 change strobe", s, e);
            chk("R6 live pattern", pin_val, m_lvl & m_dir);
            @(negedge clk);
            chk("R7 strobe lasts one cycle", pin_chg, 16'h0);
            chk("R7 reported pattern", pin_out, m_prev);
            do_rd(8'h24, v);
            chk("R5 level stored masked", v, m_lvl);
        end

        // R6 level kept across direction shrink and expand
        e = model_gpio(1'b1, 16'hFFFF); do_wr(8'h20, 16'hFFFF, s); chk("R7 open all", s, e);
        e = model_gpio(1'b0, 16'hA5A5); do_wr(8'h24, 16'hA5A5, s); chk("R7 level set", s, e);
        e = model_gpio(1'b1, 16'h00FF); do_wr(8'h20, 16'h00FF, s); chk("R6 shrink strobe", s, 16'hA500);
        do_rd(8'h24, v); chk("R6 level kept", v, 16'hA5A5);
        chk("R6 masked pattern", pin_val, 16'h00A5);
        e = model_gpio(1'b1, 16'hFFFF); do_wr(8'h20, 16'hFFFF, s); chk("R6 expand strobe", s, 16'hA500);

        // R10 back-to-back direction then level writes
        begin
            logic [15:0] e1, e2, s1, s2;
            e1 = model_gpio(1'b1, 16'h0F0F);
            e2 = model_gpio(1'b0, 16'h3C3C);
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 16'h0F0F;
            @(negedge clk);
            s1 = pin_chg;
            bus_addr = 8'h24; bus_wdata = 16'h3C3C;
            @(negedge clk);
            s2 = pin_chg;
            bus_wr = 1'b0;
            chk("R10 first strobe", s1, e1);
            chk("R10 second strobe", s2, e2);
            @(negedge clk);
            chk("R10 strobe ends", pin_chg, 16'h0);
            chk("R10 reported pattern", pin_out, 16'h0C0C);
        end

        // R8 storage write keeps pin_out
        do_wr(8'h18, 16'h7777, s);
        chk("R8 no strobe", s, 16'h0);
        @(negedge clk);
        chk("R8 pin_out stable", pin_out, m_prev);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule